// File: doc/BRIEF.md
# Cartridge-to-DRAM Byte DMA Engine

This block is a register-programmed copy engine that sits between a cartridge-side address space and main DRAM. Software programs a DRAM byte address and a cartridge address. It then writes one of two length registers, and that write both sets the byte count, as count minus one, and picks the direction. The engine decodes the cartridge address into one of two windows: a save-memory window that can be read or written, and a ROM window that can only be a source. It checks that the whole span fits inside DRAM and then moves one byte per clock through two synchronous byte ports. Every byte address on both ports is XORed with 3, which converts big-endian byte order within a word to little-endian order.

A request that cannot be served still completes. This covers a span that runs past the end of DRAM, an unmapped cartridge address, and a DRAM-to-ROM request. In each case no byte is written, busy falls and the interrupt pulses, so software always sees an end to every request it issues. When a ROM-sourced copy reaches past the end of the ROM image, the bytes beyond it are written to DRAM as zeros and the ROM is not read for them.

Top module: `cart_dma_engine`

## Requirements
- R1: After reset, busy and irq are low and both address read-back outputs are zero.
- R2: A configuration write with select 3 starts a cartridge-to-DRAM copy, and select 2 starts a DRAM-to-cartridge copy. The byte count is the written value plus one. Select 0 programs the DRAM address and select 1 programs the cartridge address. Busy rises in the cycle after the starting write.
- R3: If the DRAM address plus the byte count is larger than DRAM_BYTES, no byte is written on either port and the request still completes.
- R4: Cartridge addresses 0x08000000 through 0x08010000 inclusive select the save window, at offset (address - 0x08000000). The save window can be copied in both directions.
- R5: Cartridge addresses 0x10000000 through 0x1FBFFFFF inclusive select the ROM window, at offset (address - 0x10000000). ROM is only ever read. A DRAM-to-cartridge request aimed at it performs no copy and completes.
- R6: Byte i of a transfer accesses DRAM at (dram_addr + i) XOR 3 and the cartridge at (offset + i) XOR 3.
- R7: For a ROM-sourced copy, every byte whose unswizzled ROM offset is ROM_BYTES or more is written to DRAM as zero.
- R8: On completion busy falls, and irq is high for exactly that one cycle.
- R9: Any other cartridge address performs no copy and still completes.
- R10: The cartridge address read-back keeps the programmed value after a transfer.
- R11: Configuration writes, including new starts, are ignored while busy is high.
- R12: Busy stays high for exactly count+1 cycles for a copy that is served, and for exactly 1 cycle for a request that is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (0 DRAM addr, 1 cart addr, 2 start to cart, 3 start to DRAM) |
| cfg_wdata | input | 32 | Configuration write data |
| dram_addr_rb | output | 32 | Programmed DRAM address |
| cart_addr_rb | output | 32 | Programmed cartridge address |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle completion pulse |
| dram_en | output | 1 | DRAM port access enable |
| dram_we | output | 1 | DRAM port write enable |
| dram_addr | output | DRAM_AW | DRAM byte address (swizzled) |
| dram_wdata | output | 8 | DRAM write byte |
| dram_rdata | input | 8 | DRAM read byte, valid one cycle after the read |
| cart_en | output | 1 | Cartridge port access enable |
| cart_we | output | 1 | Cartridge port write enable |
| cart_rom | output | 1 | 1 selects ROM, 0 selects save memory |
| cart_off | output | 28 | Window byte offset (swizzled) |
| cart_wdata | output | 8 | Cartridge write byte |
| cart_rdata | input | 8 | Cartridge read byte, valid one cycle after the read |

## Verification
The hardest case to reach is a ROM copy that straddles the end of the image: it switches from real reads to zero writes partway through. The result depends on how the start offset, the byte count and the XOR-3 swizzle line up relative to the image end. The bench shrinks the ROM to 40 bytes and DRAM to 64 bytes. It then sweeps every DRAM start from 0 to 7, every ROM start from 26 to 44 and every count from 1 to 12. Its ROM model returns a marker byte beyond the image, so any read that should have been a zero fill shows up in the DRAM image.

// File: rtl/cart_dma_pkg.sv
package cart_dma_pkg;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SAVE = 2'd1,
        WIN_ROM  = 2'd2
    } win_e;

    typedef enum logic {
        DIR_TO_CART = 1'b0,
        DIR_TO_DRAM = 1'b1
    } dir_e;

    localparam logic [1:0] SEL_DRAM_ADDR   = 2'd0;
    localparam logic [1:0] SEL_CART_ADDR   = 2'd1;
    localparam logic [1:0] SEL_LEN_TO_CART = 2'd2;
    localparam logic [1:0] SEL_LEN_TO_DRAM = 2'd3;

    localparam logic [31:0] SAVE_LO = 32'h0800_0000;
    localparam logic [31:0] SAVE_HI = 32'h0801_0000;
    localparam logic [31:0] ROM_LO  = 32'h1000_0000;
    localparam logic [31:0] ROM_HI  = 32'h1FBF_FFFF;

    localparam int CART_OW = 28;

endpackage

// File: rtl/cart_dma_decode.sv
module cart_dma_decode
    import cart_dma_pkg::*;
(
    input  logic [31:0]        addr,
    output win_e               win,
    output logic [CART_OW-1:0] off
);

    always_comb begin
        win = WIN_NONE;
        off = '0;
        if (addr >= SAVE_LO && addr <= SAVE_HI) begin
            win = WIN_SAVE;
            off = CART_OW'(addr - SAVE_LO);
        end else if (addr >= ROM_LO && addr <= ROM_HI) begin
            win = WIN_ROM;
            off = CART_OW'(addr - ROM_LO);
        end
    end

endmodule

// File: rtl/cart_dma_regs.sv
module cart_dma_regs
    import cart_dma_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             busy,
    output logic [31:0]      dram_addr,
    output logic [31:0]      cart_addr,
    output logic             req,
    output dir_e             req_dir,
    output logic [LEN_W-1:0] req_len
);

    typedef struct packed {
        logic [31:0] dram_addr;
        logic [31:0] cart_addr;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d  = regs_q;
        req     = 1'b0;
        req_dir = DIR_TO_CART;
        req_len = cfg_wdata[LEN_W-1:0];
        if (cfg_we && !busy) begin
            case (cfg_sel)
                SEL_DRAM_ADDR:   regs_d.dram_addr = cfg_wdata;
                SEL_CART_ADDR:   regs_d.cart_addr = cfg_wdata;
                SEL_LEN_TO_CART: req = 1'b1;
                default: begin
                    req     = 1'b1;
                    req_dir = DIR_TO_DRAM;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign dram_addr = regs_q.dram_addr;
    assign cart_addr = regs_q.cart_addr;

    // R11
    locked_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we) |=> ($stable(dram_addr) && $stable(cart_addr)));

endmodule

// File: rtl/cart_dma_mover.sv
module cart_dma_mover
    import cart_dma_pkg::*;
#(
    parameter int DRAM_BYTES = 8388608,
    parameter int ROM_BYTES  = 16777216,
    parameter int LEN_W      = 24,
    localparam int DRAM_AW   = $clog2(DRAM_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  dir_e               req_dir,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [31:0]        dram_base,
    input  win_e               win,
    input  logic [CART_OW-1:0] cart_base,
    output logic               busy,
    output logic               irq,
    output logic               dram_en,
    output logic               dram_we,
    output logic [DRAM_AW-1:0] dram_addr,
    output logic [7:0]         dram_wdata,
    input  logic [7:0]         dram_rdata,
    output logic               cart_en,
    output logic               cart_we,
    output logic               cart_rom,
    output logic [CART_OW-1:0] cart_off,
    output logic [7:0]         cart_wdata,
    input  logic [7:0]         cart_rdata
);

    localparam logic [DRAM_AW-1:0] D_SWZ = DRAM_AW'(3);
    localparam logic [CART_OW-1:0] C_SWZ = CART_OW'(3);

    typedef struct packed {
        logic               run;
        dir_e               dir;
        logic               rom;
        logic               all_issued;
        logic [LEN_W-1:0]   idx;
        logic [LEN_W-1:0]   last;
        logic [DRAM_AW-1:0] dram_base;
        logic [CART_OW-1:0] cart_base;
        logic               pend;
        logic               pend_zero;
        logic [DRAM_AW-1:0] pend_dram;
        logic [CART_OW-1:0] pend_cart;
        logic               irq;
    } mv_t;

    mv_t mv_d, mv_q;

    logic [DRAM_AW-1:0] d_lin;
    logic [CART_OW-1:0] c_lin;
    logic               zero_byte;
    logic               issuing;
    logic [32:0]        span_end;
    logic               fits;
    logic               copy_ok;

    always_comb begin
        mv_d     = mv_q;
        mv_d.irq = 1'b0;

        d_lin     = mv_q.dram_base + DRAM_AW'(mv_q.idx);
        c_lin     = mv_q.cart_base + CART_OW'(mv_q.idx);
        zero_byte = mv_q.rom && (32'(c_lin) >= 32'(ROM_BYTES));
        issuing   = mv_q.run && !mv_q.all_issued;

        span_end = {1'b0, dram_base} + 33'(req_len) + 33'd1;
        fits     = span_end <= 33'(DRAM_BYTES);
        copy_ok  = fits && ((req_dir == DIR_TO_DRAM && win != WIN_NONE) ||
                            (req_dir == DIR_TO_CART && win == WIN_SAVE));

        dram_en    = 1'b0;
        dram_we    = 1'b0;
        dram_addr  = '0;
        dram_wdata = '0;
        cart_en    = 1'b0;
        cart_we    = 1'b0;
        cart_rom   = 1'b0;
        cart_off   = '0;
        cart_wdata = '0;

        // read side: issue byte idx
        if (issuing) begin
            if (mv_q.dir == DIR_TO_DRAM) begin
                cart_en  = !zero_byte;
                cart_rom = mv_q.rom;
                cart_off = c_lin ^ C_SWZ;
            end else begin
                dram_en   = 1'b1;
                dram_addr = d_lin ^ D_SWZ;
            end
        end

        // write side: retire the byte read one cycle earlier
        if (mv_q.pend) begin
            if (mv_q.dir == DIR_TO_DRAM) begin
                dram_en    = 1'b1;
                dram_we    = 1'b1;
                dram_addr  = mv_q.pend_dram;
                dram_wdata = mv_q.pend_zero ? 8'h00 : cart_rdata;
            end else begin
                cart_en    = 1'b1;
                cart_we    = 1'b1;
                cart_rom   = 1'b0;
                cart_off   = mv_q.pend_cart;
                cart_wdata = dram_rdata;
            end
        end

        mv_d.pend      = issuing;
        mv_d.pend_zero = zero_byte;
        mv_d.pend_dram = d_lin ^ D_SWZ;
        mv_d.pend_cart = c_lin ^ C_SWZ;

        if (issuing) begin
            mv_d.idx = mv_q.idx + 1'b1;
            if (mv_q.idx == mv_q.last) mv_d.all_issued = 1'b1;
        end

        if (mv_q.run && mv_q.all_issued) begin
            mv_d.run  = 1'b0;
            mv_d.irq  = 1'b1;
            mv_d.pend = 1'b0;
        end

        if (!mv_q.run && req) begin
            mv_d.run        = 1'b1;
            mv_d.dir        = req_dir;
            mv_d.rom        = (win == WIN_ROM);
            mv_d.idx        = '0;
            mv_d.last       = req_len;
            mv_d.dram_base  = dram_base[DRAM_AW-1:0];
            mv_d.cart_base  = cart_base;
            mv_d.all_issued = !copy_ok;
            mv_d.pend       = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mv_q <= '0;
        else        mv_q <= mv_d;
    end

    assign busy = mv_q.run;
    assign irq  = mv_q.irq;

    // R8
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8
    irq_with_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $fell(busy));

    // R2
    busy_from_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req));

    // R5
    rom_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cart_en && cart_rom) |-> !cart_we);

    // R11
    no_restart_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !irq && $past(busy)) |-> $stable(mv_q.last));

endmodule

// File: rtl/cart_dma_engine.sv
module cart_dma_engine
    import cart_dma_pkg::*;
#(
    parameter int DRAM_BYTES = 8388608,
    parameter int ROM_BYTES  = 16777216,
    parameter int LEN_W      = 24,
    localparam int DRAM_AW   = $clog2(DRAM_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        dram_addr_rb,
    output logic [31:0]        cart_addr_rb,
    output logic               busy,
    output logic               irq,
    output logic               dram_en,
    output logic               dram_we,
    output logic [DRAM_AW-1:0] dram_addr,
    output logic [7:0]         dram_wdata,
    input  logic [7:0]         dram_rdata,
    output logic               cart_en,
    output logic               cart_we,
    output logic               cart_rom,
    output logic [27:0]        cart_off,
    output logic [7:0]         cart_wdata,
    input  logic [7:0]         cart_rdata
);

    logic               req;
    dir_e               req_dir;
    logic [LEN_W-1:0]   req_len;
    win_e               win;
    logic [CART_OW-1:0] win_off;

    cart_dma_regs #(.LEN_W(LEN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .busy      (busy),
        .dram_addr (dram_addr_rb),
        .cart_addr (cart_addr_rb),
        .req       (req),
        .req_dir   (req_dir),
        .req_len   (req_len)
    );

    cart_dma_decode u_decode (
        .addr (cart_addr_rb),
        .win  (win),
        .off  (win_off)
    );

    cart_dma_mover #(
        .DRAM_BYTES (DRAM_BYTES),
        .ROM_BYTES  (ROM_BYTES),
        .LEN_W      (LEN_W)
    ) u_mover (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_dir    (req_dir),
        .req_len    (req_len),
        .dram_base  (dram_addr_rb),
        .win        (win),
        .cart_base  (win_off),
        .busy       (busy),
        .irq        (irq),
        .dram_en    (dram_en),
        .dram_we    (dram_we),
        .dram_addr  (dram_addr),
        .dram_wdata (dram_wdata),
        .dram_rdata (dram_rdata),
        .cart_en    (cart_en),
        .cart_we    (cart_we),
        .cart_rom   (cart_rom),
        .cart_off   (cart_off),
        .cart_wdata (cart_wdata),
        .cart_rdata (cart_rdata)
    );

endmodule

// File: tb/cart_dma_engine_bench.sv
module cart_dma_engine_bench;

    localparam int DB = 64;
    localparam int RB = 40;
    localparam int LW = 8;
    localparam int AW = $clog2(DB);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] dram_addr_rb, cart_addr_rb;
    logic        busy, irq;
    logic        dram_en, dram_we;
    logic [AW-1:0] dram_addr;
    logic [7:0]  dram_wdata, dram_rdata;
    logic        cart_en, cart_we, cart_rom;
    logic [27:0] cart_off;
    logic [7:0]  cart_wdata, cart_rdata;

    cart_dma_engine #(.DRAM_BYTES(DB), .ROM_BYTES(RB), .LEN_W(LW)) u_cart_dma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .dram_addr_rb(dram_addr_rb), .cart_addr_rb(cart_addr_rb), .busy(busy), .irq(irq),
        .dram_en(dram_en), .dram_we(dram_we), .dram_addr(dram_addr), .dram_wdata(dram_wdata),
        .dram_rdata(dram_rdata), .cart_en(cart_en), .cart_we(cart_we), .cart_rom(cart_rom),
        .cart_off(cart_off), .cart_wdata(cart_wdata), .cart_rdata(cart_rdata)
    );

    logic [7:0] dram_mem [DB];
    logic [7:0] exp_dram [DB];
    logic [7:0] rom_mem  [RB];
    logic [7:0] save_mem [256];
    logic [7:0] exp_save [256];

    int n_vec = 0;
    int n_bad = 0;

    always @(posedge clk) begin
        if (dram_en) begin
            if (dram_we) dram_mem[dram_addr] <= dram_wdata;
            else         dram_rdata <= dram_mem[dram_addr];
        end
        if (cart_en) begin
            if (cart_rom) begin
                if (!cart_we) cart_rdata <= (cart_off < 28'(RB)) ? rom_mem[cart_off] : 8'hEE;
            end else if (cart_we) begin
                save_mem[cart_off[7:0]] <= cart_wdata;
            end else begin
                cart_rdata <= save_mem[cart_off[7:0]];
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic compare_images(input string req);
        int bad_d = -1;
        int bad_s = -1;
        for (int i = 0; i < DB; i++)
            if (bad_d < 0 && dram_mem[i] !== exp_dram[i]) bad_d = i;
        for (int i = 0; i < 256; i++)
            if (bad_s < 0 && save_mem[i] !== exp_save[i]) bad_s = i;
        if (bad_d >= 0) check(0, req, $sformatf("dram byte %0d", bad_d), dram_mem[bad_d], exp_dram[bad_d]);
        else            check(1, req, "dram image", 0, 0);
        if (bad_s >= 0) check(0, req, $sformatf("save byte %0d", bad_s), save_mem[bad_s], exp_save[bad_s]);
        else            check(1, req, "save image", 0, 0);
    endtask

    task automatic run_xfer(input bit to_dram, input logic [31:0] da, input logic [31:0] ca,
                            input int nbytes, input bit poke, input string req);
        bit is_save = (ca >= 32'h0800_0000 && ca <= 32'h0801_0000);
        bit is_rom  = (ca >= 32'h1000_0000 && ca <= 32'h1FBF_FFFF);
        bit fits    = (longint'(da) + nbytes) <= DB;
        bit copy    = fits && (to_dram ? (is_save || is_rom) : is_save);
        int cyc = 0;
        wr_reg(2'd0, da);
        wr_reg(2'd1, ca);
        wr_reg(to_dram ? 2'd3 : 2'd2, 32'(nbytes - 1));
        // R2: busy rises after the start write
        check(busy === 1'b1, "R2", "busy after start", busy, 1);
        while (busy === 1'b1 && cyc < 1000) begin
            cyc++;
            if (poke) begin
                cfg_we    = (cyc == 1 || cyc == 2);
                cfg_sel   = (cyc == 1) ? 2'd0 : 2'd3;
                cfg_wdata = 32'h0000_0033;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0;
        // R12
        check(cyc == (copy ? nbytes + 1 : 1), "R12", "busy cycles", cyc, copy ? nbytes + 1 : 1);
        // R8
        check(irq === 1'b1, "R8", "irq at busy fall", irq, 1);
        @(negedge clk);
        check(irq === 1'b0, "R8", "irq one cycle", irq, 0);
        // R10
        check(cart_addr_rb === ca, "R10", "cart addr readback", cart_addr_rb, ca);
        // R11
        check(dram_addr_rb === da, "R11", "dram addr readback", dram_addr_rb, da);
        if (copy) begin
            for (int i = 0; i < nbytes; i++) begin
                int d = (int'(da) + i) ^ 3;
                if (to_dram && is_rom) begin
                    longint ro = longint'(ca) - 32'h1000_0000 + i;
                    exp_dram[d] = (ro < RB) ? rom_mem[int'(ro) ^ 3] : 8'h00;
                end else begin
                    int so = ((int'(ca - 32'h0800_0000) + i) ^ 3) & 255;
                    if (to_dram) exp_dram[d] = exp_save[so];
                    else         exp_save[so] = exp_dram[d];
                end
            end
        end
        compare_images(req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < RB; i++)  rom_mem[i] = 8'(i * 37 + 11);
        for (int i = 0; i < DB; i++)  begin dram_mem[i] = 8'(i ^ 8'h5A); exp_dram[i] = 8'(i ^ 8'h5A); end
        for (int i = 0; i < 256; i++) begin save_mem[i] = 8'(255 - i); exp_save[i] = 8'(255 - i); end
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        // R1
        check(busy === 1'b0 && irq === 1'b0, "R1", "busy/irq in reset", {busy, irq}, 0);
        check(dram_addr_rb === 0 && cart_addr_rb === 0, "R1", "readback in reset", dram_addr_rb | cart_addr_rb, 0);
        rst_n = 1'b1;

        // R6 R7: ROM sweep across the end of the image
        for (int da = 0; da < 8; da++)
            for (int ro = 26; ro <= 44; ro++)
                for (int n = 1; n <= 12; n++)
                    run_xfer(1'b1, 32'(da), 32'h1000_0000 + 32'(ro), n, 1'b0, "R7");

        // R4 R6: save window both directions
        for (int so = 0; so < 8; so++)
            for (int da = 8; da < 16; da++)
                for (int n = 1; n <= 8; n++) begin
                    run_xfer(1'b0, 32'(da), 32'h0800_0000 + 32'(so * 9), n, 1'b0, "R4");
                    run_xfer(1'b1, 32'(da + 24), 32'h0800_0000 + 32'(so * 5 + 40), n, 1'b0, "R6");
                end

        // R4: inclusive top of save window; R9 just past it
        run_xfer(1'b0, 32'd4,  32'h0801_0000, 4, 1'b0, "R4");
        run_xfer(1'b0, 32'd4,  32'h0801_0001, 4, 1'b0, "R9");
        // R7: top of ROM window lies past the image
        run_xfer(1'b1, 32'd40, 32'h1FBF_FFFF, 1, 1'b0, "R7");
        // R9: unmapped addresses
        run_xfer(1'b1, 32'd0,  32'h1FC0_0000, 6, 1'b0, "R9");
        run_xfer(1'b1, 32'd0,  32'h07FF_FFFF, 6, 1'b0, "R9");
        run_xfer(1'b1, 32'd0,  32'h2000_0000, 6, 1'b0, "R9");
        // R5: ROM as destination is refused
        run_xfer(1'b0, 32'd0,  32'h1000_0000, 8, 1'b0, "R5");
        // R3: DRAM bound
        run_xfer(1'b1, 32'd60, 32'h1000_0000, 5, 1'b0, "R3");
        run_xfer(1'b1, 32'd59, 32'h1000_0000, 5, 1'b0, "R3");
        run_xfer(1'b1, 32'd60, 32'h1000_0004, 4, 1'b0, "R3");
        run_xfer(1'b1, 32'd64, 32'h1000_0000, 1, 1'b0, "R3");
        run_xfer(1'b0, 32'd62, 32'h0800_0000, 3, 1'b0, "R3");
        // R11: writes during busy are dropped
        run_xfer(1'b1, 32'd16, 32'h1000_0008, 9, 1'b1, "R11");
        run_xfer(1'b0, 32'd20, 32'h0800_0010, 6, 1'b1, "R11");
        // R2: count from the written value
        run_xfer(1'b1, 32'd0,  32'h1000_0000, 40, 1'b0, "R2");

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule